// File: doc/BRIEF.md
# Cascaded DAC Update Trigger Divider

This block generates the periodic update strobe that moves every DAC channel to its new code at the same instant. Two 16-bit down-counting stages are chained: the lower stage counts clock-enable ticks, and the upper stage counts the lower stage's terminal counts. The trigger period in ticks is therefore the product of the two stage divisors. This gives a 32-bit span of division from a slow fixed-rate tick. On each trigger the block drives an active-low load pulse one system clock wide, and raises an event strobe in the same cycle that an interrupt controller can use.

Software writes each stage's divisor one byte at a time, low byte first, through a plain write strobe. A software gate input pauses counting when high. While the gate is closed, a completed divisor write restarts both stages at once. While the gate is open, a new divisor waits for the end of the current period. The system clock should be at least 20 MHz, so that the one-clock load pulse stays below 100 ns. All pins are plain control signals and no pin uses a handshake.

Top module: `dac_trigger_divider`

## Requirements
- R1: After reset, load_n is 1, trig_evt is 0 and both stage divisors are 2. With the gate open, the first trigger therefore follows the 4th accepted tick.
- R2: With the gate open, a trigger occurs once every Dlo*Dhi accepted ticks. Dlo is the divisor of stage 0, which counts ticks, and Dhi is the divisor of stage 1, which counts stage-0 wraps. load_n is low in the cycle that follows the clock edge that accepted the final tick.
- R3: Select a stage with wr_stage (0 = lower, 1 = upper). Each stage's divisor is written as two wr_en bytes: the first write gives bits [7:0] and the second gives bits [15:8]. The divisor changes only on the second byte, and each stage keeps its own byte-order toggle.
- R4: A written divisor of 0 or 1 is treated as 2.
- R5: While gate_n is 1, ticks are ignored and the count is held. Counting resumes from the same point when gate_n returns to 0.
- R6: Each trigger drives load_n low for exactly one clock. trig_evt is 1 in exactly the cycles where load_n is 0.
- R7: A divisor completed while the gate is open does not disturb the period in progress. It takes effect from the next trigger onward.
- R8: A divisor completed while the gate is closed reloads both stages from their latest divisors. The next trigger then comes after a full new period of ticks, counted once the gate reopens. The gate must stay closed for one clock after the completing write.
- R9: A cycle with tick_en at 0 does not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Clock enable of the slow counting rate |
| gate_n | input | 1 | Software gate, 0 allows counting |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_stage | input | 1 | Stage selected by the write (0 lower, 1 upper) |
| wr_byte | input | BYTE_W | Divisor byte being written |
| load_n | output | 1 | Active-low DAC update pulse |
| trig_evt | output | 1 | Trigger event strobe for interrupt use |

## Verification
A wrong count, a lost reload or a stray byte toggle inside the block shows up at the ports as a load pulse on the wrong tick. The fault becomes visible at the latest by the end of the current Dlo*Dhi period. An error in holding a pending divisor shows up one period later, as the spacing of the following trigger. The bench tracks the expected tick position of every trigger, cycle by cycle, across a sweep of small divisor pairs. The sweep mixes gating, tick gaps and divisor writes in both gate states, so any misplaced pulse is flagged in the cycle where it appears.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // Smallest divisor a stage accepts; smaller written values are raised to it.
  localparam int unsigned MIN_DIV = 2;
endpackage

// File: rtl/trig_div_loader.sv
module trig_div_loader #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              commit_o
);
  localparam int unsigned NB       = DIV_W / BYTE_W;
  localparam int unsigned PW       = (NB > 1) ? $clog2(NB) : 1;
  localparam int unsigned LAST_IDX = NB - 1;
  localparam logic [PW-1:0] LAST   = PW'(LAST_IDX);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(trig_pkg::MIN_DIV);

  logic [PW-1:0]    ptr_q;
  logic [DIV_W-1:0] asm_q;
  logic [DIV_W-1:0] full_w;
  logic [DIV_W-1:0] clamp_w;

  always_comb begin
    full_w = asm_q;
    full_w[LAST_IDX*BYTE_W +: BYTE_W] = byte_i;
    clamp_w = (full_w < FLOOR) ? FLOOR : full_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      asm_q    <= '0;
      div_o    <= FLOOR;
      commit_o <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (wr_i) begin
        if (ptr_q == LAST) begin
          div_o    <= clamp_w;
          ptr_q    <= '0;
          commit_o <= 1'b1;
        end else begin
          asm_q[int'(ptr_q)*BYTE_W +: BYTE_W] <= byte_i;
          ptr_q <= ptr_q + PW'(1);
        end
      end
    end
  end

  assert_commit_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(wr_i));
endmodule

// File: rtl/trig_cascade_stage.sv
module trig_cascade_stage #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             restart_i,
  input  logic             take_i,
  input  logic [CNT_W-1:0] pend_i,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(trig_pkg::MIN_DIV);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] reload_w;

  assign tc_o     = step_i && (cnt_q == ONE);
  assign reload_w = take_i ? pend_i : act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= RST_VAL;
    end else if (take_i) begin
      act_q <= pend_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else if (restart_i) begin
      cnt_q <= reload_w;
    end else if (step_i) begin
      cnt_q <= tc_o ? reload_w : (cnt_q - ONE);
    end
  end

  assert_cnt_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/trig_strobe_out.sv
module trig_strobe_out (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic load_no,
  output logic event_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_no <= 1'b1;
      event_o <= 1'b0;
    end else begin
      load_no <= !fire_i;
      event_o <= fire_i;
    end
  end
endmodule

// File: rtl/dac_trigger_divider.sv
module dac_trigger_divider #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              gate_n,
  input  logic              wr_en,
  input  logic              wr_stage,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              load_n,
  output logic              trig_evt
);
  localparam int unsigned NSTG = 2;

  logic [HALF_W-1:0] pend_div [NSTG];
  logic              commit_w [NSTG];
  logic              tc_w     [NSTG];
  logic              step_w   [NSTG];
  logic              stg_wr   [NSTG];
  logic              restart;
  logic              fire;
  logic              take;

  // Gate closed: any completed divisor restarts the whole chain.
  assign restart = gate_n && (commit_w[0] || commit_w[1]);
  assign fire    = tc_w[NSTG-1];
  assign take    = fire || restart;

  for (genvar g = 0; g < NSTG; g++) begin : gen_stage
    assign stg_wr[g] = wr_en && ((g == 0) ? !wr_stage : wr_stage);
    if (g == 0) begin : gen_base
      assign step_w[g] = tick_en && !gate_n;
    end else begin : gen_chain
      assign step_w[g] = tc_w[g-1];
    end

    trig_div_loader #(.DIV_W(HALF_W), .BYTE_W(BYTE_W)) u_load (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (stg_wr[g]),
      .byte_i   (wr_byte),
      .div_o    (pend_div[g]),
      .commit_o (commit_w[g])
    );

    trig_cascade_stage #(.CNT_W(HALF_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step_w[g]),
      .restart_i (restart),
      .take_i    (take),
      .pend_i    (pend_div[g]),
      .tc_o      (tc_w[g])
    );
  end

  trig_strobe_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (fire),
    .load_no (load_n),
    .event_o (trig_evt)
  );

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> load_n);
  assert_evt_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt == !load_n);
  assert_fire_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |-> $past(tick_en));
  assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_n |=> load_n);
endmodule

// File: tb/sim_dac_trigger_divider.sv
module sim_dac_trigger_divider;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       gate_n = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_stage = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       load_n;
  logic       trig_evt;

  int total = 0;
  int bad = 0;

  // Spec-level model state
  int since = 0;
  int period = 4;
  int next_period = 4;
  int divm [2] = '{2, 2};
  int lowb [2] = '{0, 0};
  bit tog  [2] = '{1'b0, 1'b0};

  dac_trigger_divider u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_n(gate_n),
    .wr_en(wr_en), .wr_stage(wr_stage), .wr_byte(wr_byte),
    .load_n(load_n), .trig_evt(trig_evt)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int actv, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  task automatic model_write(input bit st, input int b, input bit gn);
    if (!tog[st]) begin
      lowb[st] = b;
      tog[st] = 1'b1;
    end else begin
      divm[st] = b * 256 + lowb[st];
      if (divm[st] < 2) divm[st] = 2;
      tog[st] = 1'b0;
      if (gn) begin
        period = divm[0] * divm[1];
        next_period = period;
        since = 0;
      end else begin
        next_period = divm[0] * divm[1];
      end
    end
  endtask

  // Called at a negedge; drives one cycle and checks its result at the next negedge.
  task automatic cyc(input bit tk, input bit gn, input bit we, input bit st,
                     input int b, input string req);
    bit expv;
    tick_en = tk; gate_n = gn; wr_en = we; wr_stage = st; wr_byte = b[7:0];
    expv = 1'b0;
    if (tk && !gn) begin
      since++;
      if (since == period) begin
        expv = 1'b1;
        since = 0;
        period = next_period;
      end
    end
    if (we) model_write(st, b, gn);
    @(negedge clk);
    check(load_n == !expv, req, load_n, !expv);
    check(trig_evt == expv, req, trig_evt, expv);
  endtask

  task automatic wr_div(input bit st, input int v, input bit gn, input string req);
    cyc(1'b0, gn, 1'b1, st, v % 256, req);
    cyc(1'b0, gn, 1'b1, st, v / 256, req);
  endtask

  task automatic prog(input int lo, input int hi, input string req);
    wr_div(1'b0, lo, 1'b1, req);
    wr_div(1'b1, hi, 1'b1, req);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 0, req);
  endtask

  initial begin
    #(CLK_P * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check(load_n == 1'b1, "R1 reset load_n", load_n, 1);
    check(trig_evt == 1'b0, "R1 reset trig_evt", trig_evt, 0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 0, "R1 idle");
    // R1: default divisors 2 x 2
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R1 default period");

    // R2 / R4 / R5 / R9 sweep over small divisor pairs
    for (int dl = 0; dl <= 5; dl++) begin
      for (int dh = 0; dh <= 4; dh++) begin
        int p;
        prog(dl, dh, (dl < 2 || dh < 2) ? "R4 clamp program" : "R8 program");
        p = ((dl < 2) ? 2 : dl) * ((dh < 2) ? 2 : dh);
        for (int c = 0; c < 3 * p + 8; c++) begin
          bit tk, gn;
          tk = (c % 3) != 1;
          gn = (c % 13) >= 11;
          if (gn) cyc(tk, gn, 1'b0, 1'b0, 0, "R5 gate closed");
          else if (!tk) cyc(tk, gn, 1'b0, 1'b0, 0, "R9 no tick");
          else if (dl < 2 || dh < 2) cyc(tk, gn, 1'b0, 1'b0, 0, "R4 clamped period");
          else cyc(tk, gn, 1'b0, 1'b0, 0, "R2 period");
        end
      end
    end

    // R2/R3: wide divisor using the upper byte
    prog(258, 3, "R3 wide program");
    for (int i = 0; i < 1560; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R2 wide period");

    // R7 / R3: interleaved writes with the gate open
    prog(2, 3, "R7 program");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R7 run");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R7 run");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 4, "R3 low byte lower");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R3 half written");
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 5, "R3 low byte upper");
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 0, "R3 high byte upper");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R7 old period");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 0, "R3 high byte lower");
    for (int i = 0; i < 50; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R7 new period");

    // R5: pause mid-period without writes, then resume
    prog(3, 3, "R5 program");
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R5 run");
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 0, "R5 paused");
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R5 resumed");

    // R8: closed-gate write restarts both stages
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R8 run");
    wr_div(1'b0, 2, 1'b1, "R8 write closed");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 0, "R8 settle");
    for (int i = 0; i < 14; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R8 restarted period");

    // R6: pulse spacing at the smallest divisors
    prog(2, 2, "R6 program");
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R6 pulse width");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule